// File: doc/BRIEF.md
# Dual-Clock Burst-Addressed Pipelined RAM

This block is a synchronous true dual-port RAM. Each side has its own clock, its own address counter and its own registered control path. The full-size instance holds 32768 words of 18 bits (`ADDR_W = 15`). Each word is split into two 9-bit byte lanes, and each lane has its own write enable. Either side can reach any word at any time, on its own clock, including a word the other side is using. Each side first captures its address, write data, lane enables and controls on a rising edge. The next edge performs the access and loads the read result into an output register. Read data therefore appears one clock after the access is registered.

Each side's access address is not taken straight from the pins. It comes from a per-port address counter that serves burst transfers. Every cycle the counter takes exactly one of four named actions, listed here in priority order:

- `CTR_CLEAR` forces the address to zero.
- `CTR_LOAD` takes the external address.
- `CTR_STEP` adds one, wrapping from the top word to zero.
- `CTR_HOLD` keeps the address.

A side is selected only while its active-low chip select is low and its active-high chip select is high. A deselected side neither writes nor presents data. All controls are active low, except the read/write line (high means read) and the high-true chip select.

Top module: `burst_dpram`

## Requirements
- R1: A word is 18 bits, with lane 0 on bits 8..0 and lane 1 on bits 17..9. In a selected write cycle, lane k is written only while bit k of the lane-enable input is 0. A lane whose bit is 1 keeps its old contents.
- R2: A selected read with output enable low, registered on rising edge k, drives the word at the counter's updated address on the read-data port after edge k+1, with the valid flag high.
- R3: While the low-true select is 1 or the high-true select is 0, the side writes nothing. Two edges later it shows zero read data with valid low.
- R4: A selected read registered with output enable high yields zero read data and valid low, two edges later.
- R5: A counter-clear input of 0 sets the access address to zero, whatever the load and step inputs are.
- R6: With clear inactive and load at 0, the access address becomes the external address, and the step input is ignored.
- R7: With clear and load inactive and step at 0, the access address rises by one, and wraps from 2^ADDR_W-1 to 0.
- R8: With clear, load and step all inactive, the access address is kept. The counter acts in the same way whether or not the side is selected.
- R9: A word written through one side can be read through the other. Both sides may run concurrently on unrelated clocks at different addresses.
- R10: A selected write cycle yields zero read data and valid low in its output slot.
- R11: The reset input of a side clears its read data, valid flag and access address to zero. Array contents are kept across reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Side A clock |
| rst_a_n | input | 1 | Side A reset, active low |
| addr_a | input | ADDR_W | Side A external address for loads |
| wdata_a | input | LANE_W*LANES | Side A write data |
| rnw_a | input | 1 | Side A direction, 1 read, 0 write |
| oe_a_n | input | 1 | Side A output enable, active low |
| cs0_a_n | input | 1 | Side A chip select, active low |
| cs1_a | input | 1 | Side A chip select, active high |
| lane_a_n | input | LANES | Side A per-lane write enables, active low |
| ld_a_n | input | 1 | Side A counter load, active low |
| inc_a_n | input | 1 | Side A counter step, active low |
| clr_a_n | input | 1 | Side A counter clear, active low |
| rdata_a | output | LANE_W*LANES | Side A registered read data |
| rvalid_a | output | 1 | Side A read data valid |
| clk_b | input | 1 | Side B clock |
| rst_b_n | input | 1 | Side B reset, active low |
| addr_b | input | ADDR_W | Side B external address for loads |
| wdata_b | input | LANE_W*LANES | Side B write data |
| rnw_b | input | 1 | Side B direction, 1 read, 0 write |
| oe_b_n | input | 1 | Side B output enable, active low |
| cs0_b_n | input | 1 | Side B chip select, active low |
| cs1_b | input | 1 | Side B chip select, active high |
| lane_b_n | input | LANES | Side B per-lane write enables, active low |
| ld_b_n | input | 1 | Side B counter load, active low |
| inc_b_n | input | 1 | Side B counter step, active low |
| clr_b_n | input | 1 | Side B counter clear, active low |
| rdata_b | output | LANE_W*LANES | Side B registered read data |
| rvalid_b | output | 1 | Side B read data valid |

## Verification
The bench builds the block with `ADDR_W = 6`, `LANE_W = 9` and `LANES = 2`, which gives 64 words. At that depth one stepping burst fills the whole array, so every later random read has a known expected value. Counter wrap from the top word to zero can be reached in a few cycles. The two clocks run at unrelated periods, so concurrent traffic from both sides meets at arbitrary phase offsets. The lane width matches the full-size part, so lane splitting is checked exactly as the 32K instance would use it.

// File: rtl/drb_pkg.sv
package drb_pkg;

    typedef enum logic [1:0] {
        CTR_CLEAR,
        CTR_LOAD,
        CTR_STEP,
        CTR_HOLD
    } ctr_op_e;

    // Priority: clear, then load, then step, else hold.
    function automatic ctr_op_e ctr_decode(input logic clr_n, input logic ld_n, input logic inc_n);
        ctr_op_e op;
        if (!clr_n)      op = CTR_CLEAR;
        else if (!ld_n)  op = CTR_LOAD;
        else if (!inc_n) op = CTR_STEP;
        else             op = CTR_HOLD;
        return op;
    endfunction

endpackage

// File: rtl/drb_addr_ctr.sv
module drb_addr_ctr
    import drb_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              ld_n,
    input  logic              inc_n,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] cur_addr
);

    ctr_op_e           op;
    logic [ADDR_W-1:0] nxt_addr;

    always_comb op = ctr_decode(clr_n, ld_n, inc_n);

    always_comb begin
        unique case (op)
            CTR_CLEAR: nxt_addr = '0;
            CTR_LOAD:  nxt_addr = ext_addr;
            CTR_STEP:  nxt_addr = cur_addr + ADDR_W'(1);
            CTR_HOLD:  nxt_addr = cur_addr;
            default:   nxt_addr = cur_addr;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_addr <= '0;
        else        cur_addr <= nxt_addr;
    end

    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> cur_addr == '0);

    assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !ld_n) |=> cur_addr == $past(ext_addr));

    assert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && ld_n && !inc_n) |=> cur_addr == $past(cur_addr) + ADDR_W'(1));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && ld_n && inc_n) |=> $stable(cur_addr));

endmodule

// File: rtl/drb_port.sv
module drb_port #(
    parameter int ADDR_W = 12,
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    localparam int WORD_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              rnw,
    input  logic              oe_n,
    input  logic              cs0_n,
    input  logic              cs1,
    input  logic [LANES-1:0]  lane_n,
    input  logic              ld_n,
    input  logic              inc_n,
    input  logic              clr_n,
    // array side
    output logic [ADDR_W-1:0] acc_addr,
    output logic [LANES-1:0]  wr_lane,
    output logic [WORD_W-1:0] wr_word,
    input  logic [WORD_W-1:0] mem_word,
    // read side
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid
);

    // Stage 1: registered controls and data.
    logic              sel_q;
    logic              rnw_q;
    logic              oe_n_q;
    logic [LANES-1:0]  lane_n_q;
    logic [WORD_W-1:0] din_q;
    logic              rd_go;

    drb_addr_ctr #(.ADDR_W(ADDR_W)) ctr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_n    (clr_n),
        .ld_n     (ld_n),
        .inc_n    (inc_n),
        .ext_addr (ext_addr),
        .cur_addr (acc_addr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q    <= 1'b0;
            rnw_q    <= 1'b1;
            oe_n_q   <= 1'b1;
            lane_n_q <= '1;
            din_q    <= '0;
        end else begin
            sel_q    <= !cs0_n && cs1;
            rnw_q    <= rnw;
            oe_n_q   <= oe_n;
            lane_n_q <= lane_n;
            din_q    <= wdata;
        end
    end

    always_comb begin
        wr_word = din_q;
        wr_lane = (sel_q && !rnw_q) ? ~lane_n_q : '0;
        rd_go   = sel_q && rnw_q && !oe_n_q;
    end

    // Stage 2: output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd_go;
            rdata  <= rd_go ? mem_word : '0;
        end
    end

    assert_desel_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs0_n || !cs1) |-> ##2 (!rvalid && rdata == '0));

    assert_desel_nowrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs0_n || !cs1) |=> wr_lane == '0);

    assert_oe_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> ##2 !rvalid);

    assert_write_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rnw |-> ##2 (!rvalid && rdata == '0));

endmodule

// File: rtl/drb_bank.sv
module drb_bank #(
    parameter int ADDR_W = 12,
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    localparam int WORD_W = LANE_W * LANES,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic [LANES-1:0]  wr_lane,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [ADDR_W-1:0] rd_addr_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    output logic [WORD_W-1:0] rd_word_a,
    output logic [WORD_W-1:0] rd_word_b
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_lane[g]) store[wr_addr] <= wr_word[g*LANE_W +: LANE_W];
        end

        assign rd_word_a[g*LANE_W +: LANE_W] = store[rd_addr_a];
        assign rd_word_b[g*LANE_W +: LANE_W] = store[rd_addr_b];
    end

endmodule

// File: rtl/burst_dpram.sv
module burst_dpram #(
    parameter int ADDR_W = 12,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                     clk_a,
    input  logic                     rst_a_n,
    input  logic [ADDR_W-1:0]        addr_a,
    input  logic [LANE_W*LANES-1:0]  wdata_a,
    input  logic                     rnw_a,
    input  logic                     oe_a_n,
    input  logic                     cs0_a_n,
    input  logic                     cs1_a,
    input  logic [LANES-1:0]         lane_a_n,
    input  logic                     ld_a_n,
    input  logic                     inc_a_n,
    input  logic                     clr_a_n,
    output logic [LANE_W*LANES-1:0]  rdata_a,
    output logic                     rvalid_a,
    input  logic                     clk_b,
    input  logic                     rst_b_n,
    input  logic [ADDR_W-1:0]        addr_b,
    input  logic [LANE_W*LANES-1:0]  wdata_b,
    input  logic                     rnw_b,
    input  logic                     oe_b_n,
    input  logic                     cs0_b_n,
    input  logic                     cs1_b,
    input  logic [LANES-1:0]         lane_b_n,
    input  logic                     ld_b_n,
    input  logic                     inc_b_n,
    input  logic                     clr_b_n,
    output logic [LANE_W*LANES-1:0]  rdata_b,
    output logic                     rvalid_b
);

    localparam int WORD_W = LANE_W * LANES;

    logic [ADDR_W-1:0] acc_a, acc_b;
    logic [LANES-1:0]  wl_a, wl_b;
    logic [WORD_W-1:0] ww_a, ww_b;
    logic [WORD_W-1:0] ba_at_a, ba_at_b, bb_at_a, bb_at_b;
    logic [WORD_W-1:0] word_a, word_b;
    logic [WORD_W-1:0] bank_in_a, bank_in_b;

    // A stored word is the XOR of both banks; each bank has one writer.
    always_comb begin
        word_a    = ba_at_a ^ bb_at_a;
        word_b    = ba_at_b ^ bb_at_b;
        bank_in_a = ww_a ^ bb_at_a;
        bank_in_b = ww_b ^ ba_at_b;
    end

    drb_port #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) port_a_i (
        .clk (clk_a), .rst_n (rst_a_n), .ext_addr (addr_a), .wdata (wdata_a),
        .rnw (rnw_a), .oe_n (oe_a_n), .cs0_n (cs0_a_n), .cs1 (cs1_a),
        .lane_n (lane_a_n), .ld_n (ld_a_n), .inc_n (inc_a_n), .clr_n (clr_a_n),
        .acc_addr (acc_a), .wr_lane (wl_a), .wr_word (ww_a), .mem_word (word_a),
        .rdata (rdata_a), .rvalid (rvalid_a)
    );

    drb_port #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) port_b_i (
        .clk (clk_b), .rst_n (rst_b_n), .ext_addr (addr_b), .wdata (wdata_b),
        .rnw (rnw_b), .oe_n (oe_b_n), .cs0_n (cs0_b_n), .cs1 (cs1_b),
        .lane_n (lane_b_n), .ld_n (ld_b_n), .inc_n (inc_b_n), .clr_n (clr_b_n),
        .acc_addr (acc_b), .wr_lane (wl_b), .wr_word (ww_b), .mem_word (word_b),
        .rdata (rdata_b), .rvalid (rvalid_b)
    );

    drb_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) bank_a_i (
        .clk (clk_a), .wr_lane (wl_a), .wr_addr (acc_a), .wr_word (bank_in_a),
        .rd_addr_a (acc_a), .rd_addr_b (acc_b),
        .rd_word_a (ba_at_a), .rd_word_b (ba_at_b)
    );

    drb_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) bank_b_i (
        .clk (clk_b), .wr_lane (wl_b), .wr_addr (acc_b), .wr_word (bank_in_b),
        .rd_addr_a (acc_a), .rd_addr_b (acc_b),
        .rd_word_a (bb_at_a), .rd_word_b (bb_at_b)
    );

    assert_reset_a_R11: assert property (@(posedge clk_a)
        !rst_a_n |-> (rdata_a == '0 && !rvalid_a));

    assert_reset_b_R11: assert property (@(posedge clk_b)
        !rst_b_n |-> (rdata_b == '0 && !rvalid_b));

endmodule

// File: tb/burst_dpram_tb_top.sv
module burst_dpram_tb_top;

    localparam int CLK_PERIOD   = 10;
    localparam int CLK_B_PERIOD = CLK_PERIOD + 4;
    localparam int AW    = 6;
    localparam int LW    = 9;
    localparam int NL    = 2;
    localparam int WW    = LW * NL;
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic          clr_n;
        logic          ld_n;
        logic          inc_n;
        logic          rnw;
        logic          oe_n;
        logic          cs0_n;
        logic          cs1;
        logic [NL-1:0] lane_n;
        logic [AW-1:0] addr;
        logic [WW-1:0] data;
    } op_t;

    logic clk_a = 1'b0;
    logic clk_b = 1'b0;
    logic rst_n;
    always #(CLK_PERIOD/2)   clk_a = ~clk_a;
    always #(CLK_B_PERIOD/2) clk_b = ~clk_b;

    op_t           drv [2];
    logic [WW-1:0] rd_o [2];
    logic          vld_o [2];

    burst_dpram #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL)) dut_i (
        .clk_a (clk_a), .rst_a_n (rst_n), .addr_a (drv[0].addr), .wdata_a (drv[0].data),
        .rnw_a (drv[0].rnw), .oe_a_n (drv[0].oe_n), .cs0_a_n (drv[0].cs0_n), .cs1_a (drv[0].cs1),
        .lane_a_n (drv[0].lane_n), .ld_a_n (drv[0].ld_n), .inc_a_n (drv[0].inc_n),
        .clr_a_n (drv[0].clr_n), .rdata_a (rd_o[0]), .rvalid_a (vld_o[0]),
        .clk_b (clk_b), .rst_b_n (rst_n), .addr_b (drv[1].addr), .wdata_b (drv[1].data),
        .rnw_b (drv[1].rnw), .oe_b_n (drv[1].oe_n), .cs0_b_n (drv[1].cs0_n), .cs1_b (drv[1].cs1),
        .lane_b_n (drv[1].lane_n), .ld_b_n (drv[1].ld_n), .inc_b_n (drv[1].inc_n),
        .clr_b_n (drv[1].clr_n), .rdata_b (rd_o[1]), .rvalid_b (vld_o[1])
    );

    int total = 0;
    int bad   = 0;

    logic [WW-1:0] mem_m [DEPTH];
    logic [AW-1:0] ctr_m [2];
    logic          pend_have [2];
    logic          pend_vld [2];
    logic [WW-1:0] pend_dat [2];
    string         pend_tag [2];

    task automatic chk(string tag, string what, logic [WW-1:0] act, logic [WW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic op_t nop_op();
        op_t o;
        o = '0;
        o.clr_n = 1'b1; o.ld_n = 1'b1; o.inc_n = 1'b1; o.rnw = 1'b1;
        o.oe_n = 1'b1; o.cs0_n = 1'b1; o.cs1 = 1'b0; o.lane_n = '1;
        return o;
    endfunction

    function automatic op_t mk(logic clr_n, logic ld_n, logic inc_n, logic rnw,
                               logic [NL-1:0] lane_n, logic [AW-1:0] addr, logic [WW-1:0] data);
        op_t o;
        o = nop_op();
        o.clr_n = clr_n; o.ld_n = ld_n; o.inc_n = inc_n; o.rnw = rnw;
        o.oe_n = 1'b0; o.cs0_n = 1'b0; o.cs1 = 1'b1;
        o.lane_n = lane_n; o.addr = addr; o.data = data;
        return o;
    endfunction

    // mode 0: full range; 1: lower half, load only; 2: upper half, load only
    function automatic op_t rand_op(int mode);
        op_t o;
        o.clr_n  = ($urandom_range(15) != 0);
        o.ld_n   = $urandom_range(1) != 0;
        o.inc_n  = $urandom_range(1) != 0;
        o.rnw    = $urandom_range(1) != 0;
        o.oe_n   = ($urandom_range(7) == 0);
        o.cs0_n  = ($urandom_range(7) == 0);
        o.cs1    = ($urandom_range(7) != 0);
        o.lane_n = NL'($urandom);
        o.addr   = AW'($urandom);
        o.data   = WW'($urandom);
        if (mode != 0) begin
            o.clr_n = 1'b1;
            o.ld_n  = 1'b0;
            o.addr[AW-1] = (mode == 2);
        end
        return o;
    endfunction

    task automatic wait_edge(int p, bit rise);
        if (p == 0) begin
            if (rise) @(posedge clk_a); else @(negedge clk_a);
        end else begin
            if (rise) @(posedge clk_b); else @(negedge clk_b);
        end
    endtask

    // Called at a falling edge of port p's clock; returns at the next one.
    task automatic step(int p, op_t o, string tag);
        logic          sel;
        logic          e_vld;
        logic [WW-1:0] e_dat;
        drv[p] = o;
        if (!o.clr_n)      ctr_m[p] = '0;
        else if (!o.ld_n)  ctr_m[p] = o.addr;
        else if (!o.inc_n) ctr_m[p] = ctr_m[p] + AW'(1);
        sel   = !o.cs0_n && o.cs1;
        e_vld = sel && o.rnw && !o.oe_n;
        e_dat = e_vld ? mem_m[ctr_m[p]] : '0;
        if (sel && !o.rnw) begin
            for (int k = 0; k < NL; k++)
                if (!o.lane_n[k]) mem_m[ctr_m[p]][k*LW +: LW] = o.data[k*LW +: LW];
        end
        wait_edge(p, 1'b1);
        wait_edge(p, 1'b0);
        if (pend_have[p]) begin
            chk(pend_tag[p], $sformatf("port%0d rdata", p), rd_o[p], pend_dat[p]);
            chk(pend_tag[p], $sformatf("port%0d rvalid", p), WW'(vld_o[p]), WW'(pend_vld[p]));
        end
        pend_have[p] = 1'b1;
        pend_vld[p]  = e_vld;
        pend_dat[p]  = e_dat;
        pend_tag[p]  = tag;
    endtask

    task automatic drain(int p);
        step(p, nop_op(), "R3");
        step(p, nop_op(), "R3");
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wait_edge(0, 1'b1);
        wait_edge(1, 1'b1);
        wait_edge(0, 1'b0);
        rst_n = 1'b1;
        ctr_m[0] = '0; ctr_m[1] = '0;
        pend_have[0] = 1'b0; pend_have[1] = 1'b0;
    endtask

    task automatic main_seq();
        logic [WW-1:0] old;
        void'($urandom(32'd20240611));
        drv[0] = nop_op();
        drv[1] = nop_op();
        do_reset();
        // R11: outputs clear after reset
        chk("R11", "rdata_a after reset", rd_o[0], '0);
        chk("R11", "rvalid_a after reset", WW'(vld_o[0]), '0);
        chk("R11", "rdata_b after reset", rd_o[1], '0);
        chk("R11", "rvalid_b after reset", WW'(vld_o[1]), '0);

        // Fill the array with one stepping write burst (R7)
        step(0, mk(1, 0, 1, 0, 2'b00, '0, WW'($urandom)), "R10");
        for (int i = 1; i < DEPTH; i++)
            step(0, mk(1, 1, 0, 0, 2'b00, '0, WW'($urandom)), "R10");
        drain(0);

        // R1: lane writes
        step(0, mk(1, 0, 1, 0, 2'b00, AW'(5), 18'h2_AAAA), "R1");
        step(0, mk(1, 1, 1, 0, 2'b10, AW'(5), 18'h1_5555), "R1");
        step(0, mk(1, 1, 1, 1, 2'b11, AW'(5), '0), "R1");
        step(0, mk(1, 1, 1, 0, 2'b01, AW'(5), 18'h3_FFFF), "R1");
        step(0, mk(1, 1, 1, 1, 2'b11, AW'(5), '0), "R1");
        drain(0);

        // R3: deselected writes are dropped
        old = mem_m[5];
        begin
            op_t o;
            o = mk(1, 0, 1, 0, 2'b00, AW'(5), 18'h0_1234);
            o.cs1 = 1'b0;
            step(0, o, "R3");
            o.cs1 = 1'b1; o.cs0_n = 1'b1;
            step(0, o, "R3");
            o = mk(1, 0, 1, 1, 2'b11, AW'(5), '0);
            o.cs0_n = 1'b1;
            step(0, o, "R3");
            // R4: output enable off
            o = mk(1, 0, 1, 1, 2'b11, AW'(5), '0);
            o.oe_n = 1'b1;
            step(0, o, "R4");
        end
        step(0, mk(1, 1, 1, 1, 2'b11, '0, '0), "R3");
        drain(0);
        chk("R3", "word 5 kept after deselected writes", mem_m[5], old);

        // R7: wrap; R5 clear priority; R6 load beats step; R8 hold
        step(0, mk(1, 0, 1, 1, 2'b11, AW'(DEPTH-2), '0), "R7");
        step(0, mk(1, 1, 0, 1, 2'b11, '0, '0), "R7");
        step(0, mk(1, 1, 0, 1, 2'b11, '0, '0), "R7");
        step(0, mk(0, 0, 0, 1, 2'b11, AW'(9), '0), "R5");
        step(0, mk(1, 0, 0, 1, 2'b11, AW'(20), '0), "R6");
        step(0, mk(1, 1, 1, 1, 2'b11, AW'(33), '0), "R8");
        begin
            op_t o;
            o = mk(1, 1, 0, 1, 2'b11, '0, '0);
            o.cs1 = 1'b0;                       // counter steps while deselected
            step(0, o, "R8");
        end
        step(0, mk(1, 1, 1, 1, 2'b11, '0, '0), "R8");
        drain(0);

        // R9: port B reads words written by A, then writes, A reads back
        step(1, mk(1, 0, 1, 1, 2'b11, AW'(5), '0), "R9");
        step(1, mk(1, 1, 0, 1, 2'b11, '0, '0), "R9");
        step(1, mk(1, 0, 1, 0, 2'b00, AW'(40), 18'h2_C3A5), "R9");
        drain(1);
        step(0, mk(1, 0, 1, 1, 2'b11, AW'(40), '0), "R9");
        drain(0);

        // R2: random traffic, one side at a time
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < 150; i++) step(0, rand_op(0), "R2");
            drain(0);
            for (int i = 0; i < 150; i++) step(1, rand_op(0), "R2");
            drain(1);
        end

        // R9: both sides concurrently on disjoint halves
        fork
            begin
                for (int i = 0; i < 200; i++) step(0, rand_op(1), "R9");
                drain(0);
            end
            begin
                for (int i = 0; i < 150; i++) step(1, rand_op(2), "R9");
                drain(1);
            end
        join

        // R11: counter cleared by reset, array kept
        step(0, mk(1, 0, 1, 1, 2'b11, AW'(17), '0), "R11");
        drain(0);
        do_reset();
        step(0, mk(1, 1, 1, 1, 2'b11, '0, '0), "R11");
        drain(0);
    endtask

    initial begin
        bit timed_out;
        timed_out = 1'b0;
        rst_n  = 1'b0;
        drv[0] = nop_op();
        drv[1] = nop_op();
        pend_have[0] = 1'b0;
        pend_have[1] = 1'b0;
        fork
            main_seq();
            begin
                #(CLK_B_PERIOD * 20000);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule